// File: doc/BRIEF.md
# Modem Line Status Register with Change Tracking

This block holds the modem status byte of a 16550-style serial port. Every clock it samples four modem input lines: clear-to-send, data-set-ready, ring indicator and carrier detect. It keeps their present levels in the upper half of an 8-bit status value. The lower half holds one sticky change flag per line, so software can see that a line moved even if it has already moved back. An interrupt request is raised while any change flag is set and the modem-status interrupt enable is high.

A read strobe stands for a CPU read of the register. In the strobe cycle, `rd_data` presents the value before it is cleared. At the closing clock edge all change flags are cleared. A line change that arrives in the same cycle as the read is not lost: it sets its flag again. A loopback mode swaps the external lines for four modem control outputs, which lets software test the path without a cable. The lines are assumed to be synchronised before they reach this block. The register has no data stream, so it has no valid/ready handshake and no back-pressure: every pin is a plain level or a one-cycle strobe.

Top module: `modem_status_reg`

## Requirements
- R1: After reset, `rd_data` reads 8'hB0 (carrier detect, data-set-ready and clear-to-send high, ring low, no change flags) and `irq` is low.
- R2: The upper nibble of `rd_data` shows the sampled line levels one clock after they are presented: bit 4 clear-to-send, bit 5 data-set-ready, bit 6 ring indicator, bit 7 carrier detect.
- R3: A change in either direction of clear-to-send, data-set-ready or carrier detect sets change flag bit 0, bit 1 or bit 3 respectively, in the same cycle the new level appears in the upper nibble.
- R4: Ring change flag bit 2 is set only when the ring line goes from 1 to 0. A 0-to-1 ring transition leaves it unchanged.
- R5: Change flags are sticky. Further line activity, including a return to the earlier level, never clears them.
- R6: While `rd_strobe` is high, `rd_data` shows the value before clearing. After that clock edge the four change flags are zero and the upper nibble is unchanged.
- R7: A line change presented in the same cycle as `rd_strobe` sets its change flag after the read instead of being dropped.
- R8: While `loop_en` is high, clear-to-send follows `ctl_rts`, data-set-ready follows `ctl_dtr`, ring follows `ctl_out1` and carrier detect follows `ctl_out2`. The external line inputs are then ignored.
- R9: With `msi_en` high, `irq` is high exactly while any change flag is set, so it drops in the cycle after a read clears the flags.
- R10: With `msi_en` low, `irq` stays low, but change flags are still recorded and assert `irq` as soon as `msi_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_cts | input | 1 | External clear-to-send level |
| line_dsr | input | 1 | External data-set-ready level |
| line_ri | input | 1 | External ring indicator level |
| line_dcd | input | 1 | External carrier detect level |
| loop_en | input | 1 | Loopback mode select |
| ctl_dtr | input | 1 | Modem control DTR output bit, loops to data-set-ready |
| ctl_rts | input | 1 | Modem control RTS output bit, loops to clear-to-send |
| ctl_out1 | input | 1 | Modem control user output 1, loops to ring |
| ctl_out2 | input | 1 | Modem control user output 2, loops to carrier detect |
| msi_en | input | 1 | Modem-status interrupt enable |
| rd_strobe | input | 1 | One-cycle register read, clears change flags at the edge |
| rd_data | output | 8 | Status value: levels in bits 7:4, change flags in bits 3:0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
All state is visible on `rd_data` with one register stage, so a wrong level or a lost flag shows up at the port one clock after the stimulus. A flag that clears itself, or that fails to clear on a read, appears in the cycle after the edge concerned. A wrong ring edge polarity only shows on a 0-to-1 ring step, so both directions are driven, and the read-collision case is driven deliberately. Interrupt gating errors show on `irq` in the same cycle that `msi_en` or a flag changes.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINES  = 4;
  localparam int DATA_W = 2 * LINES;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  // level after reset: carrier, data-set-ready, clear-to-send high
  localparam logic [LINES-1:0] RST_LEVELS = 4'b1011;
  // lines whose change flag reacts only to a 1->0 step
  localparam logic [LINES-1:0] FALL_ONLY  = 4'b0100;
endpackage

// File: rtl/msr_line_sel.sv
module msr_line_sel #(
  parameter int W = 4
) (
  input  logic [W-1:0] ext_lines,
  input  logic [W-1:0] loop_lines,
  input  logic         loop_en,
  output logic [W-1:0] lines_out
);
  always_comb lines_out = loop_en ? loop_lines : ext_lines;
endmodule

// File: rtl/msr_delta_track.sv
module msr_delta_track #(
  parameter int              W          = 4,
  parameter logic [W-1:0]    RST_LEVELS = '0,
  parameter logic [W-1:0]    FALL_ONLY  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines_in,
  input  logic         rd_clr,
  output logic [W-1:0] levels,
  output logic [W-1:0] deltas
);
  logic [W-1:0] chg;

  for (genvar i = 0; i < W; i++) begin : g_line
    if (FALL_ONLY[i]) begin : g_fall
      always_comb chg[i] = levels[i] & ~lines_in[i];
    end else begin : g_any
      always_comb chg[i] = levels[i] ^ lines_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      levels <= RST_LEVELS;
      deltas <= '0;
    end else begin
      levels <= lines_in;
      deltas <= (rd_clr ? '0 : deltas) | chg;
    end
  end

  // R5: with no read and no line movement, flags hold
  a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && lines_in == levels) |=> $stable(deltas));
  // R6: a read with quiet lines leaves all flags clear
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && lines_in == levels) |=> deltas == '0);
  // R2: levels follow the sampled lines one clock later
  a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> levels == $past(lines_in));

  for (genvar j = 0; j < W; j++) begin : g_chk
    if (FALL_ONLY[j]) begin : g_fall_chk
      // R4: a rising ring step does not raise its flag
      a_r4_rise_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !deltas[j] && !levels[j] && lines_in[j]) |=> !deltas[j]);
    end else begin : g_any_chk
      // R3 and R7: any step raises the flag, read or not
      a_r3_step_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (levels[j] != lines_in[j]) |=> deltas[j]);
    end
  end
endmodule

// File: rtl/msr_irq_gen.sv
module msr_irq_gen #(
  parameter int W = 4
) (
  input  logic [W-1:0] deltas,
  input  logic         enable,
  output logic         irq
);
  always_comb irq = enable & (|deltas);
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_cts,
  input  logic              line_dsr,
  input  logic              line_ri,
  input  logic              line_dcd,
  input  logic              loop_en,
  input  logic              ctl_dtr,
  input  logic              ctl_rts,
  input  logic              ctl_out1,
  input  logic              ctl_out2,
  input  logic              msi_en,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [LINES-1:0] ext_lines, loop_lines, sel_lines, levels, deltas;

  always_comb begin
    ext_lines           = '0;
    ext_lines[IDX_CTS]  = line_cts;
    ext_lines[IDX_DSR]  = line_dsr;
    ext_lines[IDX_RI]   = line_ri;
    ext_lines[IDX_DCD]  = line_dcd;
    loop_lines          = '0;
    loop_lines[IDX_CTS] = ctl_rts;
    loop_lines[IDX_DSR] = ctl_dtr;
    loop_lines[IDX_RI]  = ctl_out1;
    loop_lines[IDX_DCD] = ctl_out2;
  end

  msr_line_sel #(.W(LINES)) u_sel (
    .ext_lines (ext_lines),
    .loop_lines(loop_lines),
    .loop_en   (loop_en),
    .lines_out (sel_lines)
  );

  msr_delta_track #(
    .W         (LINES),
    .RST_LEVELS(RST_LEVELS),
    .FALL_ONLY (FALL_ONLY)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_in(sel_lines),
    .rd_clr  (rd_strobe),
    .levels  (levels),
    .deltas  (deltas)
  );

  msr_irq_gen #(.W(LINES)) u_irq (
    .deltas(deltas),
    .enable(msi_en),
    .irq   (irq)
  );

  always_comb rd_data = {levels, deltas};

  // R9: a request always has a flag behind it
  a_r9_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_data[LINES-1:0] != '0);
  // R10: no request while the enable is low
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq);
  // R8: in loopback, clear-to-send reports the RTS control bit
  a_r8_loop_cts: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> rd_data[LINES+IDX_CTS] == $past(ctl_rts));
endmodule

// File: tb/modem_status_reg_tb.sv
module modem_status_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_cts = 1'b1, line_dsr = 1'b1, line_ri = 1'b0, line_dcd = 1'b1;
  logic loop_en = 1'b0, ctl_dtr = 1'b0, ctl_rts = 1'b0, ctl_out1 = 1'b0, ctl_out2 = 1'b0;
  logic msi_en = 1'b0, rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modem_status_reg u_dut (
    .clk(clk), .rst_n(rst_n),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri), .line_dcd(line_dcd),
    .loop_en(loop_en), .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts),
    .ctl_out1(ctl_out1), .ctl_out2(ctl_out2),
    .msi_en(msi_en), .rd_strobe(rd_strobe), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // read with clear; checks the value seen during the strobe
  task automatic do_read(input string req, input logic [7:0] exp_before);
    rd_strobe = 1'b1;
    #1;
    check(req, rd_data, exp_before);
    tick();
    rd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset value", rd_data, 8'hB0);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_steps();
    line_cts = 1'b0; tick();
    check("R2 R3 cts fall", rd_data, 8'hA1);
    line_dcd = 1'b0; tick();
    check("R3 dcd fall", rd_data, 8'h29);
    do_read("R6 read value", 8'h29);
    check("R6 cleared", rd_data, 8'h20);
    line_cts = 1'b1; line_dcd = 1'b1; tick();
    check("R3 rising steps", rd_data, 8'hB9);
    do_read("R6 read value 2", 8'hB9);
    check("R6 cleared 2", rd_data, 8'hB0);
  endtask

  task automatic t_ring();
    line_ri = 1'b1; tick();
    check("R4 ring rise no flag", rd_data, 8'hF0);
    line_ri = 1'b0; tick();
    check("R4 ring fall flag", rd_data, 8'hB4);
    do_read("R6 ring read", 8'hB4);
    check("R6 ring cleared", rd_data, 8'hB0);
  endtask

  task automatic t_sticky();
    line_cts = 1'b0; tick();
    check("R5 set", rd_data, 8'hA1);
    line_cts = 1'b1; tick();
    check("R5 sticky after return", rd_data, 8'hB1);
    do_read("R5 read", 8'hB1);
    check("R5 cleared", rd_data, 8'hB0);
  endtask

  task automatic t_collide();
    line_dsr = 1'b0;
    do_read("R7 read during change", 8'hB0);
    check("R7 change kept", rd_data, 8'h92);
    line_dsr = 1'b1; tick();
    check("R7 restore", rd_data, 8'hB2);
    do_read("R7 read 2", 8'hB2);
    check("R7 cleared", rd_data, 8'hB0);
  endtask

  task automatic t_irq();
    msi_en = 1'b0;
    line_cts = 1'b0; tick();
    check("R10 flag recorded", rd_data, 8'hA1);
    check("R10 irq gated", {7'b0, irq}, 8'h00);
    msi_en = 1'b1; #1;
    check("R10 irq on enable", {7'b0, irq}, 8'h01);
    do_read("R9 read", 8'hA1);
    check("R9 irq drops", {7'b0, irq}, 8'h00);
    line_cts = 1'b1; tick();
    check("R9 irq on flag", {7'b0, irq}, 8'h01);
    do_read("R9 read 2", 8'hB1);
    check("R9 irq low again", {7'b0, irq}, 8'h00);
    msi_en = 1'b0;
  endtask

  task automatic t_loop();
    loop_en = 1'b1; tick();
    check("R8 loop entry", rd_data, 8'h0B);
    line_cts = 1'b0; line_dcd = 1'b0; line_ri = 1'b1; tick();
    check("R8 external ignored", rd_data, 8'h0B);
    do_read("R8 read", 8'h0B);
    check("R8 cleared", rd_data, 8'h00);
    ctl_rts = 1'b1; tick();
    check("R8 rts to cts", rd_data, 8'h11);
    ctl_dtr = 1'b1; tick();
    check("R8 dtr to dsr", rd_data, 8'h33);
    ctl_out2 = 1'b1; tick();
    check("R8 out2 to dcd", rd_data, 8'hBB);
    ctl_out1 = 1'b1; tick();
    check("R8 out1 to ri rise", rd_data, 8'hFB);
    ctl_out1 = 1'b0; tick();
    check("R8 R4 out1 fall", rd_data, 8'hBF);
    do_read("R8 read 2", 8'hBF);
    line_cts = 1'b1; line_dcd = 1'b1; line_ri = 1'b0;
    loop_en = 1'b0; tick();
    check("R8 exit no change", rd_data, 8'hB0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_steps();
    t_ring();
    t_sticky();
    t_collide();
    t_irq();
    t_loop();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule